// File: doc/BRIEF.md
# Peripheral clock gating controller

This block holds the clock-enable bits for up to 32 peripherals, with one enable set for each of three power modes: run, sleep and deep-sleep. Software programs the three sets through a small single-cycle register port. Every clock cycle the block picks one set from the current power mode and an auto-gating control bit, and registers it. It then passes each enable through a clock-low-transparent latch to produce one gated clock per peripheral.

The block also sees each bus transfer aimed at a peripheral, given as a valid strobe and a peripheral index. When the indexed peripheral is unclocked under the active set, it raises a bus-fault response in the same cycle and withholds the grant, so that no data moves. Only the peripheral bits that exist can be written. All other bits read as zero, and an access to a peripheral index that has no writable bit always faults.

Top module: `pclk_gate_ctrl`

## Requirements
- R1: Three 32-bit enable registers can be written and read back: run set at byte offset 0x0, sleep set at 0x4 and deep-sleep set at 0x8 (address bits [3:2] = 0, 1, 2). Read data is combinational from the current address while `bus_sel`=1 and `bus_we`=0, and is zero otherwise.
- R2: In every register only bits 0–6, 13, 28 and 30 (mask 0x5000207F) can be written. Every other bit reads as zero and ignores writes. Offset 0xC holds no register: it reads as zero and a write there changes nothing.
- R3: After a synchronous active-low reset, all three registers read 0x00000000, every enable output is 0 and every gated clock is held low.
- R4: While `auto_gate`=0 the run set is the active set, whatever the `pwr_mode` code.
- R5: While `auto_gate`=1, `pwr_mode` 2'b01 selects the sleep set and 2'b10 selects the deep-sleep set. Codes 2'b00 and 2'b11 select the run set.
- R6: The active set is registered. A change of mode, of `auto_gate` or of a register value takes effect one clock edge after the edge that samples it. A register write is therefore visible on the enables two edges after the write is driven.
- R7: Each enable output is latched while the clock is low and held while it is high. Each gated clock equals the clock ANDed with its latched enable.
- R8: When `periph_acc`=1 and the active enable bit at `periph_idx` is 0, `bus_fault`=1 and `periph_grant`=0 in that same cycle. When the bit is 1, `periph_grant`=1 and `bus_fault`=0. With `periph_acc`=0 both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register port transfer valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| pwr_mode | input | 2 | Power mode: 00 run, 01 sleep, 10 deep-sleep |
| auto_gate | input | 1 | Lets the sleep and deep-sleep sets take effect |
| periph_acc | input | 1 | A bus transfer targets a peripheral |
| periph_idx | input | 5 | Index of the targeted peripheral |
| bus_fault | output | 1 | Fault response: the target is unclocked |
| periph_grant | output | 1 | Transfer may proceed |
| periph_clk_en | output | 32 | Latched enable for each peripheral |
| periph_gclk | output | 32 | Gated clock for each peripheral |

## Verification
The assertions check on every cycle that:
- writes to the run register keep only the writable mask;
- read data never carries a reserved bit;
- the active set follows the run, sleep or deep-sleep register one edge later, according to mode and auto-gating;
- a fault never appears without a peripheral access, or together with a grant.

Only the bench scenarios can show the full mode table against distinct programmed patterns, the exact two-edge latency from a write to an enable, the high-phase and low-phase values of the gated clocks, the reset contents, and the faults on gated and nonexistent peripheral indexes.

// File: rtl/pclk_gate_pkg.sv
// Shared constants and types for the peripheral clock gating controller.
// Assumes a 32-bit register width and word-aligned register offsets.
package pclk_gate_pkg;

    localparam int unsigned REG_W = 32;

    // Power-mode code presented on the pwr_mode input.
    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_SLEEP = 2'b01,
        PM_DEEP  = 2'b10,
        PM_RSVD  = 2'b11
    } pwr_mode_e;

    // Word index of each enable register (bus_addr[3:2]).
    localparam logic [1:0] WIDX_RUN  = 2'd0;
    localparam logic [1:0] WIDX_SLP  = 2'd1;
    localparam logic [1:0] WIDX_DSLP = 2'd2;

    // Bits that exist as peripheral enables: GPIO 0-6, DMA 13, MAC 28, PHY 30.
    localparam logic [REG_W-1:0] DEFAULT_WMASK = 32'h5000_207F;

endpackage

// File: rtl/pclk_gate_regfile.sv
// Register file holding the run, sleep and deep-sleep enable sets.
// Assumes a single-cycle bus: writes land on the next clock edge and reads are
// combinational. Bits outside WMASK are held at zero.
module pclk_gate_regfile #(
    parameter int unsigned     W     = 32,
    parameter logic [W-1:0]    WMASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_we,
    input  logic [3:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic [W-1:0] run_q,
    output logic [W-1:0] slp_q,
    output logic [W-1:0] dslp_q
);
    import pclk_gate_pkg::*;

    localparam int unsigned NREG = 3;

    logic [W-1:0] regs_q [NREG];
    logic [1:0]   widx;

    assign widx = bus_addr[3:2];

    // One storage word per power mode; only masked bits are kept.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin  // write or clear one enable set
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (bus_sel && bus_we && (widx == 2'(g))) begin
                regs_q[g] <= bus_wdata & WMASK;
            end
        end
    end

    // Read mux: registers by word index; unmapped offset and writes read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            unique case (widx)
                WIDX_RUN:  bus_rdata = regs_q[0];
                WIDX_SLP:  bus_rdata = regs_q[1];
                WIDX_DSLP: bus_rdata = regs_q[2];
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign run_q  = regs_q[0];
    assign slp_q  = regs_q[1];
    assign dslp_q = regs_q[2];

endmodule

// File: rtl/pclk_gate_mode_sel.sv
// Picks the active enable set from power mode and auto-gating, and registers it.
// Assumes the mode code is synchronous to clk; the reserved code 11 selects run.
module pclk_gate_mode_sel #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   pwr_mode,
    input  logic         auto_gate,
    input  logic [W-1:0] run_q,
    input  logic [W-1:0] slp_q,
    input  logic [W-1:0] dslp_q,
    output logic [W-1:0] sel_q
);
    import pclk_gate_pkg::*;

    logic [W-1:0] sel_d;

    // Choose the enable set; sleep sets apply only under auto-gating.
    always_comb begin
        sel_d = run_q;
        if (auto_gate) begin
            unique case (pwr_mode_e'(pwr_mode))
                PM_SLEEP: sel_d = slp_q;
                PM_DEEP:  sel_d = dslp_q;
                default:  sel_d = run_q;
            endcase
        end
    end

    // Register the chosen set so the latches see a stable value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

endmodule

// File: rtl/pclk_gate_latch_bank.sv
// Behavioural clock-gate bank: a latch open while clk is low feeds an AND gate,
// so a change of enable never cuts a high clock phase short.
// Assumes en_d changes only just after the rising edge of clk.
module pclk_gate_latch_bank #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic [N-1:0] en_d,
    output logic [N-1:0] en_l,
    output logic [N-1:0] gclk
);
    for (genvar i = 0; i < N; i++) begin : g_cg
        // Capture the enable during the low phase and hold it through the high phase.
        always_latch begin
            if (!clk) begin
                en_l[i] = en_d[i];
            end
        end
        assign gclk[i] = clk & en_l[i];
    end

endmodule

// File: rtl/pclk_gate_ctrl.sv
// Top level of the peripheral clock gating controller. It ties together the
// register file, the mode selector, the gate bank and the fault check.
// Assumes one peripheral transfer at most per cycle, indexed by periph_idx.
module pclk_gate_ctrl #(
    parameter int unsigned               NUM_PERIPH = pclk_gate_pkg::REG_W,
    parameter logic [NUM_PERIPH-1:0]     WMASK      = pclk_gate_pkg::DEFAULT_WMASK,
    localparam int unsigned              IDX_W      = $clog2(NUM_PERIPH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [3:0]            bus_addr,
    input  logic [NUM_PERIPH-1:0] bus_wdata,
    output logic [NUM_PERIPH-1:0] bus_rdata,
    input  logic [1:0]            pwr_mode,
    input  logic                  auto_gate,
    input  logic                  periph_acc,
    input  logic [IDX_W-1:0]      periph_idx,
    output logic                  bus_fault,
    output logic                  periph_grant,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic [NUM_PERIPH-1:0] periph_gclk
);
    logic [NUM_PERIPH-1:0] run_q;
    logic [NUM_PERIPH-1:0] slp_q;
    logic [NUM_PERIPH-1:0] dslp_q;
    logic [NUM_PERIPH-1:0] sel_q;
    logic                  tgt_on;

    pclk_gate_regfile #(.W(NUM_PERIPH), .WMASK(WMASK)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .run_q     (run_q),
        .slp_q     (slp_q),
        .dslp_q    (dslp_q)
    );

    pclk_gate_mode_sel #(.W(NUM_PERIPH)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_mode  (pwr_mode),
        .auto_gate (auto_gate),
        .run_q     (run_q),
        .slp_q     (slp_q),
        .dslp_q    (dslp_q),
        .sel_q     (sel_q)
    );

    pclk_gate_latch_bank #(.N(NUM_PERIPH)) u_cg (
        .clk  (clk),
        .en_d (sel_q),
        .en_l (periph_clk_en),
        .gclk (periph_gclk)
    );

    // Fault check: a transfer to an unclocked target is refused in the same cycle.
    assign tgt_on       = sel_q[periph_idx];
    assign bus_fault    = periph_acc & ~tgt_on;
    assign periph_grant = periph_acc &  tgt_on;

endmodule

// File: rtl/pclk_gate_chk.sv
// Assertion checker for pclk_gate_ctrl, attached through bind.
// Assumes it sees the top's internal register and selection buses.
module pclk_gate_chk #(
    parameter int unsigned W     = 32,
    parameter logic [W-1:0] WMASK = '1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_sel,
    input logic         bus_we,
    input logic [3:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [1:0]   pwr_mode,
    input logic         auto_gate,
    input logic         periph_acc,
    input logic         bus_fault,
    input logic         periph_grant,
    input logic [W-1:0] run_q,
    input logic [W-1:0] slp_q,
    input logic [W-1:0] dslp_q,
    input logic [W-1:0] sel_q
);
    // R1 R2: a run-register write stores exactly the masked data
    p_write_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr[3:2] == 2'd0)
        |=> (run_q == ($past(bus_wdata) & WMASK)));

    // R2: reserved bits never appear on read data
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & ~WMASK) == '0));

    // R4: without auto-gating the run set follows one edge later
    p_run_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_gate |=> (sel_q == $past(run_q)));

    // R5 R6: sleep set applies under auto-gating in sleep mode
    p_sleep_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_gate && pwr_mode == 2'b01) |=> (sel_q == $past(slp_q)));

    // R5 R6: deep-sleep set applies under auto-gating in deep-sleep mode
    p_deep_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_gate && pwr_mode == 2'b10) |=> (sel_q == $past(dslp_q)));

    // R8: a fault needs an access and excludes a grant
    p_fault_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fault |-> (periph_acc && !periph_grant));

endmodule

bind pclk_gate_ctrl pclk_gate_chk #(.W(NUM_PERIPH), .WMASK(WMASK)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pwr_mode     (pwr_mode),
    .auto_gate    (auto_gate),
    .periph_acc   (periph_acc),
    .bus_fault    (bus_fault),
    .periph_grant (periph_grant),
    .run_q        (run_q),
    .slp_q        (slp_q),
    .dslp_q       (dslp_q),
    .sel_q        (sel_q)
);

// File: tb/pclk_gate_ctrl_bench.sv
// Self-checking bench for pclk_gate_ctrl: a mode table walked by a loop,
// then directed tests for reset, reserved bits, latency, gated clocks and faults.
module pclk_gate_ctrl_bench;

    localparam logic [31:0] MASK   = 32'h5000_207F;
    localparam logic [31:0] RUN_V  = 32'hFFFF_FFFF & MASK;  // 0x5000207F
    localparam logic [31:0] SLP_V  = 32'h0000_0055;
    localparam logic [31:0] DSLP_V = 32'h1000_2003;

    typedef struct packed {
        logic        ag;
        logic [1:0]  md;
        logic [31:0] exp;
    } vec_t;

    // R4 R5: expected active set for each auto-gating / mode pair
    localparam vec_t VEC [8] = '{
        '{1'b0, 2'b00, RUN_V},
        '{1'b0, 2'b01, RUN_V},
        '{1'b0, 2'b10, RUN_V},
        '{1'b0, 2'b11, RUN_V},
        '{1'b1, 2'b00, RUN_V},
        '{1'b1, 2'b01, SLP_V},
        '{1'b1, 2'b10, DSLP_V},
        '{1'b1, 2'b11, RUN_V}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwr_mode = 2'b00;
    logic        auto_gate = 1'b0;
    logic        periph_acc = 1'b0;
    logic [4:0]  periph_idx = '0;
    logic        bus_fault;
    logic        periph_grant;
    logic [31:0] periph_clk_en;
    logic [31:0] periph_gclk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pclk_gate_ctrl u_pclk_gate_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .pwr_mode      (pwr_mode),
        .auto_gate     (auto_gate),
        .periph_acc    (periph_acc),
        .periph_idx    (periph_idx),
        .bus_fault     (bus_fault),
        .periph_grant  (periph_grant),
        .periph_clk_en (periph_clk_en),
        .periph_gclk   (periph_gclk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one register: driven after a falling edge, stored at the next rising edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // Read one register combinationally, in the low phase.
    task automatic rd(input logic [3:0] a, input string req, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2;
        chk(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    // Set mode, let one edge register it, and check the latched enables in the low phase.
    task automatic mode_chk(input logic ag, input logic [1:0] md, input string req,
                            input logic [31:0] exp);
        @(negedge clk);
        auto_gate = ag; pwr_mode = md;
        @(negedge clk);
        #2;
        chk(req, periph_clk_en, exp);
    endtask

    task automatic acc_chk(input logic [4:0] idx, input logic exp_f, input string req);
        @(negedge clk);
        periph_acc = 1'b1; periph_idx = idx;
        #2;
        chk(req, {30'd0, bus_fault, periph_grant}, {30'd0, exp_f, ~exp_f});
        periph_acc = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: reset contents, enables and gated clocks
        rd(4'h0, "R3 run reset", 32'h0);
        rd(4'h4, "R3 sleep reset", 32'h0);
        rd(4'h8, "R3 deep reset", 32'h0);
        #1 chk("R3 enables reset", periph_clk_en, 32'h0);
        @(posedge clk); #3;
        chk("R3 gclk low", periph_gclk, 32'h0);

        // R1 R2: program three distinct sets; reserved bits drop
        wr(4'h0, 32'hFFFF_FFFF);
        wr(4'h4, 32'hAFFF_DF55);   // reserved bits set, writable part 0x55
        wr(4'h8, DSLP_V);
        rd(4'h0, "R2 run masked", RUN_V);
        rd(4'h4, "R2 sleep reserved ignored", SLP_V);
        rd(4'h8, "R1 deep readback", DSLP_V);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, "R2 unmapped reads zero", 32'h0);
        rd(4'h0, "R2 unmapped write no effect", RUN_V);

        // R4 R5: mode table
        for (int i = 0; i < 8; i++) begin
            mode_chk(VEC[i].ag, VEC[i].md,
                     VEC[i].ag ? "R5 mode select" : "R4 run forced", VEC[i].exp);
        end

        // R7: gated clock follows enable in the high phase, low in the low phase
        mode_chk(1'b1, 2'b01, "R5 sleep again", SLP_V);
        @(posedge clk); #3;
        chk("R7 gclk high phase", periph_gclk, SLP_V);
        @(negedge clk); #3;
        chk("R7 gclk low phase", periph_gclk, 32'h0);

        // R8: faults under the sleep set (bit1 clear, bit0 set, bit20 reserved)
        acc_chk(5'd1, 1'b1, "R8 gated fault");
        acc_chk(5'd0, 1'b0, "R8 enabled grant");
        acc_chk(5'd20, 1'b1, "R8 reserved index fault");
        @(negedge clk); #2;
        chk("R8 idle no fault", {30'd0, bus_fault, periph_grant}, 32'h0);

        // R6: write latency to the enables while the sleep set is active
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h4000_0000;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        #2 chk("R6 one edge after write unchanged", periph_clk_en, SLP_V);
        @(negedge clk); #2;
        chk("R6 two edges after write", periph_clk_en, 32'h4000_0000);
        acc_chk(5'd30, 1'b0, "R8 newly enabled grant");

        // R6: mode change visible one edge later, not before
        @(negedge clk);
        pwr_mode = 2'b10;
        #2 chk("R6 mode change not yet", periph_clk_en, 32'h4000_0000);
        @(negedge clk); #2;
        chk("R6 mode change applied", periph_clk_en, DSLP_V);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule